// File: doc/BRIEF.md
# General-Purpose I/O Port with Edge Interrupts

A parameterized port of general-purpose pins driven through a small register bank. Each pin can be set as an input or an output. It can have a pull device, a reduced-drive option and an open-drain output mode. It can also raise a latched interrupt on a chosen edge of its synchronized input level. One polarity bit per pin sets two things at once: the direction of the pull device and the edge that sets the interrupt flag.

Software writes the configuration registers through a single-cycle write strobe. It reads any register through a combinational read address. The data address returns mixed contents. An output pin reads back its output latch, and an input pin reads back its synchronized level. A separate pin-level address always shows the synchronized pad level, so a shorted or overloaded output can be seen. Interrupt flags are cleared by writing ones to them. A single interrupt line combines every flag that is enabled.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads zero, no pad is driven (pad_oe = 0), no pull is enabled, and irq is 0.
- R2: pad_out always equals the output latch (address 0 write). A pin whose direction bit (address 2) is 1 has pad_oe set when open-drain mode is off for that pin.
- R3: When the open-drain bit (address 6) is 1 for an output pin, the pad is driven only while the latch bit is 0. pad_oe is then the inverse of the latch bit, so a high is never actively driven.
- R4: pad_pull_en equals the pull-enable bit (address 3) for input pins and is 0 for output pins. pad_pull_dn equals the polarity bit (address 4), where 1 means pull-down.
- R5: Reading address 0 returns the output latch bit for pins with direction 1 and the synchronized pad level for pins with direction 0.
- R6: Reading address 1 returns the synchronized pad level for every pin, whatever its direction. Writes to address 1 have no effect.
- R7: When the polarity bit is 1, a rising synchronized level sets that pin's flag. When it is 0, a falling level sets it. The opposite edge does not set the flag.
- R8: Flags read at address 8. Writing 1 to a flag bit clears it, writing 0 leaves it unchanged, and a flag stays set until it is cleared.
- R9: If an edge and a clear of the same flag bit occur in the same cycle, the flag ends set.
- R10: irq is 1 exactly when some flag bit and its enable bit (address 7) are both 1. A masked flag still latches.
- R11: pad_low_drive equals the reduced-drive register (address 5). Addresses above 8 read as zero.
- R12: A pad change passes through a two-stage synchronizer. It is visible at addresses 0 and 1 after the second rising clock edge, and it sets its flag at the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write address |
| reg_wdata | input | WIDTH | Write data |
| reg_raddr | input | 4 | Read address |
| reg_rdata | output | WIDTH | Read data (combinational) |
| pad_in | input | WIDTH | Raw pad levels |
| pad_out | output | WIDTH | Value presented to pad drivers |
| pad_oe | output | WIDTH | Pad driver enables |
| pad_pull_en | output | WIDTH | Pull device enables |
| pad_pull_dn | output | WIDTH | Pull direction, 1 = down |
| pad_low_drive | output | WIDTH | Reduced drive strength enables |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check on every cycle the following: the synchronizer stage ordering, that uncleared flags persist, that an edge beats a same-cycle clear, that no output pad drives high in open-drain mode, that no pull is enabled on an output pin, and that irq stays low with all enables off. The bench scenarios are the only way to show the rest. These are the edge polarity selection, the mixed read-back of the data address, the pin-level address exposing a short, and the exact cycle in which a pad change appears. The bench sweeps all direction patterns against fixed latch and open-drain patterns to cover the driver enables.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int unsigned GPIO_ADDR_W = 4;

   typedef enum logic [GPIO_ADDR_W-1:0] {
      GP_DATA = 4'd0,
      GP_PIN  = 4'd1,
      GP_DIR  = 4'd2,
      GP_PULL = 4'd3,
      GP_POL  = 4'd4,
      GP_DRV  = 4'd5,
      GP_ODRN = 4'd6,
      GP_IEN  = 4'd7,
      GP_FLAG = 4'd8
   } gpio_reg_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_pin_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= async_in;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign sync_out = chain[LAST];

   // R12: the final stage always carries what the previous stage held one edge earlier
   assert_sync_order_R12: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (sync_out == $past(chain[LAST-1])));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic [WIDTH-1:0] pol,
   input  logic [WIDTH-1:0] ien,
   input  logic [WIDTH-1:0] clr,
   output logic [WIDTH-1:0] flags,
   output logic             irq
);
   logic [WIDTH-1:0] level_d;
   logic [WIDTH-1:0] hit;

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      always_comb begin
         if (pol[b]) hit[b] = level[b] & ~level_d[b];
         else        hit[b] = ~level[b] & level_d[b];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_d <= '0;
         flags   <= '0;
      end else begin
         level_d <= level;
         flags   <= (flags & ~clr) | hit;
      end
   end

   assign irq = |(flags & ien);

   // R8: flags not targeted by a clear survive to the next cycle
   assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));

   // R9: a detected edge wins over a same-cycle clear
   assert_edge_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|(hit & clr)) |=> ((flags & $past(hit & clr)) == $past(hit & clr)));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_pkg::*;
#(
   parameter int unsigned WIDTH        = 8,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          HAS_OPENDRN  = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [GPIO_ADDR_W-1:0] reg_waddr,
   input  logic [WIDTH-1:0]       reg_wdata,
   input  logic [GPIO_ADDR_W-1:0] reg_raddr,
   output logic [WIDTH-1:0]       reg_rdata,
   input  logic [WIDTH-1:0]       pad_in,
   output logic [WIDTH-1:0]       pad_out,
   output logic [WIDTH-1:0]       pad_oe,
   output logic [WIDTH-1:0]       pad_pull_en,
   output logic [WIDTH-1:0]       pad_pull_dn,
   output logic [WIDTH-1:0]       pad_low_drive,
   output logic                   irq
);
   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("gpio_port: WIDTH must lie in 1..32");
   end

   logic [WIDTH-1:0] out_q, dir_q, pull_q, pol_q, drv_q, ien_q, odrn_q;
   logic [WIDTH-1:0] pin_sync, flags, clr_mask;

   function automatic logic hit(input logic [GPIO_ADDR_W-1:0] a, input gpio_reg_e r);
      return reg_we && (a == r);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '0;
         pull_q <= '0;
         pol_q  <= '0;
         drv_q  <= '0;
         ien_q  <= '0;
      end else begin
         if (hit(reg_waddr, GP_DATA)) out_q  <= reg_wdata;
         if (hit(reg_waddr, GP_DIR))  dir_q  <= reg_wdata;
         if (hit(reg_waddr, GP_PULL)) pull_q <= reg_wdata;
         if (hit(reg_waddr, GP_POL))  pol_q  <= reg_wdata;
         if (hit(reg_waddr, GP_DRV))  drv_q  <= reg_wdata;
         if (hit(reg_waddr, GP_IEN))  ien_q  <= reg_wdata;
      end
   end

   if (HAS_OPENDRN) begin : g_odrn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  odrn_q <= '0;
         else if (hit(reg_waddr, GP_ODRN)) odrn_q <= reg_wdata;
      end
   end else begin : g_no_odrn
      assign odrn_q = '0;
   end

   assign clr_mask = hit(reg_waddr, GP_FLAG) ? reg_wdata : '0;

   gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pad_in),
      .sync_out (pin_sync)
   );

   gpio_edge_irq #(.WIDTH(WIDTH)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .level (pin_sync),
      .pol   (pol_q),
      .ien   (ien_q),
      .clr   (clr_mask),
      .flags (flags),
      .irq   (irq)
   );

   assign pad_out       = out_q;
   assign pad_oe        = dir_q & ~(odrn_q & out_q);
   assign pad_pull_en   = pull_q & ~dir_q;
   assign pad_pull_dn   = pol_q;
   assign pad_low_drive = drv_q;

   always_comb begin
      case (reg_raddr)
         GP_DATA: reg_rdata = (out_q & dir_q) | (pin_sync & ~dir_q);
         GP_PIN:  reg_rdata = pin_sync;
         GP_DIR:  reg_rdata = dir_q;
         GP_PULL: reg_rdata = pull_q;
         GP_POL:  reg_rdata = pol_q;
         GP_DRV:  reg_rdata = drv_q;
         GP_ODRN: reg_rdata = odrn_q;
         GP_IEN:  reg_rdata = ien_q;
         GP_FLAG: reg_rdata = flags;
         default: reg_rdata = '0;
      endcase
   end

   // R3: an open-drain pin never actively drives a high level
   assert_odrn_no_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & pad_out & odrn_q) == '0));

   // R4: pulls stay off on pins configured as outputs
   assert_pull_off_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_pull_en & dir_q) == '0));

   // R10: with every enable cleared the combined interrupt stays low
   assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |-> !irq);

   // R1: nothing is driven in the first cycle after reset
   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_oe == '0));
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
   localparam int W = 8;
   localparam logic [3:0] A_DATA = 4'd0, A_PIN = 4'd1, A_DIR = 4'd2, A_PULL = 4'd3,
                          A_POL = 4'd4, A_DRV = 4'd5, A_ODRN = 4'd6, A_IEN = 4'd7,
                          A_FLAG = 4'd8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [3:0] reg_waddr = '0, reg_raddr = '0;
   logic [W-1:0] reg_wdata = '0, reg_rdata, pad_in = '0;
   logic [W-1:0] pad_out, pad_oe, pad_pull_en, pad_pull_dn, pad_low_drive;
   logic irq;
   int n_chk = 0, n_fail = 0;

   always #5 clk = ~clk;

   gpio_port u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .pad_pull_en(pad_pull_en), .pad_pull_dn(pad_pull_dn),
      .pad_low_drive(pad_low_drive), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
      reg_raddr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [W-1:0] v, od, ol;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      // R1: reset state
      for (int a = 0; a <= 8; a++) begin
         rd(a[3:0], v);
         chk($sformatf("R1 reg %0d", a), v, 0);
      end
      chk("R1 oe", pad_oe, 0);
      chk("R1 pull", pad_pull_en, 0);
      chk("R1 irq", irq, 0);

      // R11: readback of config registers, reduced drive, unmapped addresses
      wr(A_DRV, 8'h81);
      chk("R11 low drive", pad_low_drive, 8'h81);
      rd(A_DRV, v);  chk("R11 drv read", v, 8'h81);
      rd(4'd9, v);   chk("R11 unmapped 9", v, 0);
      rd(4'd15, v);  chk("R11 unmapped 15", v, 0);

      // R2 / R3: sweep every direction pattern
      od = 8'h3C;
      ol = 8'h5A;
      wr(A_ODRN, od);
      wr(A_DATA, ol);
      for (int d = 0; d < 256; d++) begin
         wr(A_DIR, d[7:0]);
         chk($sformatf("R2 out dir=%0h", d), pad_out, ol);
         chk($sformatf("R3 oe dir=%0h", d), pad_oe,
             d[7:0] & ((~od) | (od & ~ol)));
      end
      wr(A_ODRN, 8'h00);
      wr(A_DIR, 8'hFF);
      chk("R2 push-pull oe", pad_oe, 8'hFF);

      // R4: pull enable and direction
      wr(A_DIR, 8'hF0);
      wr(A_PULL, 8'hFF);
      wr(A_POL, 8'h0F);
      chk("R4 pull en", pad_pull_en, 8'h0F);
      chk("R4 pull dn", pad_pull_dn, 8'h0F);

      // R5 / R6 / R12: mixed read-back and synchronizer latency
      wr(A_DATA, 8'hA5);
      @(negedge clk) pad_in = 8'h3C;
      @(negedge clk);
      rd(A_PIN, v);  chk("R12 not yet after one edge", v, 0);
      @(negedge clk);
      rd(A_PIN, v);  chk("R12 pin after two edges", v, 8'h3C);
      rd(A_DATA, v); chk("R5 mixed data", v, (8'hA5 & 8'hF0) | (8'h3C & 8'h0F));
      wr(A_PIN, 8'hFF);
      rd(A_PIN, v);  chk("R6 pin write ignored", v, 8'h3C);
      for (int d = 0; d < 256; d += 17) begin
         wr(A_DIR, d[7:0]);
         rd(A_DATA, v);
         chk($sformatf("R5 dir=%0h", d), v, (8'hA5 & d[7:0]) | (8'h3C & ~d[7:0]));
         rd(A_PIN, v);
         chk($sformatf("R6 dir=%0h", d), v, 8'h3C);
      end

      // R7 / R8: edge polarity, bits 0-3 rising, 4-7 falling
      @(negedge clk) pad_in = 8'h00;
      wait_n(4);
      wr(A_FLAG, 8'hFF);
      @(negedge clk) pad_in = 8'hFF;
      wait_n(2);
      rd(A_FLAG, v); chk("R12 flag not before third edge", v, 0);
      @(negedge clk);
      rd(A_FLAG, v); chk("R7 rising sets low half", v, 8'h0F);
      wr(A_FLAG, 8'hFF);
      rd(A_FLAG, v); chk("R8 clear all", v, 0);
      @(negedge clk) pad_in = 8'h00;
      wait_n(3);
      rd(A_FLAG, v); chk("R7 falling sets high half", v, 8'hF0);
      wr(A_FLAG, 8'h30);
      rd(A_FLAG, v); chk("R8 partial clear", v, 8'hC0);
      wr(A_FLAG, 8'h00);
      rd(A_FLAG, v); chk("R8 zero write no effect", v, 8'hC0);

      // R10: masking
      chk("R10 all masked", irq, 0);
      wr(A_IEN, 8'h01);
      chk("R10 enable without flag", irq, 0);
      wr(A_IEN, 8'h80);
      chk("R10 enabled flag", irq, 1);
      wr(A_IEN, 8'h00);

      // R9: rising edge on bit 0 coincides with clearing every flag
      @(negedge clk) pad_in = 8'h01;
      wait_n(1);
      @(negedge clk);
      reg_we = 1'b1; reg_waddr = A_FLAG; reg_wdata = 8'hFF;
      @(negedge clk);
      reg_we = 1'b0;
      rd(A_FLAG, v); chk("R9 edge beats clear", v, 8'h01);
      wr(A_IEN, 8'h01);
      chk("R10 irq from bit0", irq, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule